// File: doc/BRIEF.md
# Pre-Triggered Gated Charge Integrator

This block measures the charge of a detector pulse. It keeps a short history of the 16-bit sample stream in a circular buffer. When a trigger is accepted, it sums baseline-corrected samples over a gate. The gate begins a programmable number of samples before the trigger and runs for a programmable number of samples from the trigger onward.

The 32-bit sum is scaled by a 16-bit fractional gain and clipped to a 16-bit energy word. That word is delivered with a one-cycle valid strobe. If a second trigger arrives inside a programmable inhibit window, the event is rejected as pileup and no energy is delivered.

The trigger comes from outside the block. The energy words are consumed by a downstream histogrammer.

Top module: `pretrig_charge_integrator`

## Requirements
- R1: After reset, energy is 0 and energyVld, pileup, intGate and busy are all low.
- R2: A trigger accepted at clock edge T integrates N = max(1, P + intLen) consecutive samples, starting with the sample present at edge T-P, where P is the effective pre-trigger length. intGate is high for exactly N cycles, starting right after edge T.
- R3: Each integrated sample contributes (sampleIn - baseline + offset) to a 32-bit signed sum. In this expression sampleIn and baseline are unsigned, and offset is a 16-bit two's-complement value.
- R4: The energy is floor(sum * gain / 65536). It is 0xFFFF when that value exceeds 65535, and 0 when the sum is negative.
- R5: The result is produced at edge F = T + max(N, pileLen) + 1. At that edge energy is updated, and energyVld is high for the following cycle only.
- R6: A trigger at any edge from T+1 through T+pileLen marks the event as pileup. At edge F, pileup then pulses for one cycle, energyVld stays low and energy keeps its previous value.
- R7: busy is high from edge T until edge F. A trigger while busy is high, including one at edge F, neither starts an integration nor changes the gate or result timing.
- R8: The effective pre-trigger length P is preLen, clamped to PRE_DEPTH-1 (63 by default).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rstN | input | 1 | Active-low synchronous reset |
| sampleIn | input | 16 | Unsigned sample stream |
| trigIn | input | 1 | Pulse trigger |
| intLen | input | 16 | Samples integrated from the trigger onward |
| preLen | input | 16 | Samples integrated before the trigger |
| pileLen | input | 16 | Pileup inhibit window in cycles after the trigger |
| gain | input | 16 | Unsigned gain, scaled by 1/65536 |
| offset | input | 16 | Signed per-sample offset |
| baseline | input | 16 | Baseline subtracted from each sample |
| energy | output | 16 | Last accepted energy |
| energyVld | output | 1 | One-cycle strobe on a new energy |
| pileup | output | 1 | One-cycle strobe on a rejected event |
| intGate | output | 1 | High while samples are accumulated |
| busy | output | 1 | High while an event is in progress |

## Verification
The hardest cases to reach are triggers that land exactly on a window edge. One case is a second trigger at the last inhibit cycle. Another is a trigger just past that cycle while the gate is still open. A third is a trigger on the very edge where the result is released, when the inhibit window outlasts the gate. The stimulus places each secondary trigger by its edge index relative to the accepted trigger, and the pre-trigger samples come from a stream that is a known function of the edge index. Together these let the expected sum, the expected result edge and the accept-or-reject decision all be computed in advance.

// File: rtl/qint_pkg.sv
package qint_pkg;
  // strobes from control to datapath
  typedef struct packed {
    logic start;   // capture read pointer, clear sum
    logic accEn;   // add one corrected sample
    logic latch;   // load scaled energy
  } qintStrobe_t;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_GATE,
    ST_HOLD
  } qintState_t;
endpackage

// File: rtl/qint_ctrl.sv
module qint_ctrl
  import qint_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             trigIn,
  input  logic [CNT_W-1:0] preEff,
  input  logic [CNT_W-1:0] intLen,
  input  logic [CNT_W-1:0] pileLen,
  output qintStrobe_t      stb,
  output logic             energyVld,
  output logic             pileup,
  output logic             intGate,
  output logic             busy
);
  localparam int LEN_W = CNT_W + 1;

  qintState_t       state;
  logic [LEN_W-1:0] gateCnt;
  logic [CNT_W-1:0] pileCnt;
  logic             pileFlag;
  logic [LEN_W-1:0] gateLen;
  logic [LEN_W-1:0] gateLenEff;
  logic             finishNow;
  logic             pileHit;

  assign gateLen    = {1'b0, preEff} + {1'b0, intLen};
  assign gateLenEff = (gateLen == '0) ? LEN_W'(1) : gateLen;
  assign finishNow  = (state == ST_HOLD) && (pileCnt == '0);
  assign pileHit    = trigIn && (pileCnt != '0);

  always_comb begin
    stb.start = (state == ST_IDLE) && trigIn;
    stb.accEn = (state == ST_GATE);
    stb.latch = finishNow && !pileFlag;
  end

  assign intGate = (state == ST_GATE);
  assign busy    = (state != ST_IDLE);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      gateCnt   <= '0;
      pileCnt   <= '0;
      pileFlag  <= 1'b0;
      energyVld <= 1'b0;
      pileup    <= 1'b0;
    end else begin
      energyVld <= 1'b0;
      pileup    <= 1'b0;
      if (stb.start)           pileCnt <= pileLen;
      else if (pileCnt != '0)  pileCnt <= pileCnt - 1'b1;
      case (state)
        ST_IDLE: begin
          if (trigIn) begin
            state    <= ST_GATE;
            gateCnt  <= gateLenEff;
            pileFlag <= 1'b0;
          end
        end
        ST_GATE: begin
          if (pileHit) pileFlag <= 1'b1;
          gateCnt <= gateCnt - 1'b1;
          if (gateCnt == LEN_W'(1)) state <= ST_HOLD;
        end
        ST_HOLD: begin
          if (finishNow) begin
            state     <= ST_IDLE;
            energyVld <= !pileFlag;
            pileup    <= pileFlag;
          end else if (pileHit) begin
            pileFlag <= 1'b1;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R7: busy only rises on a trigger seen while idle
  p_start_trig_r7: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> $past(trigIn));

  // R5: a valid result coincides with the end of the event
  p_vld_end_r5: assert property (@(posedge clk) disable iff (!rstN)
    energyVld |-> $fell(busy));
endmodule

// File: rtl/qint_datapath.sv
module qint_datapath
  import qint_pkg::*;
#(
  parameter int DATA_W    = 16,
  parameter int ACC_W     = 32,
  parameter int GAIN_W    = 16,
  parameter int PRE_DEPTH = 64,   // power of two
  localparam int AW       = $clog2(PRE_DEPTH)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [DATA_W-1:0] sampleIn,
  input  logic [DATA_W-1:0] baseline,
  input  logic [DATA_W-1:0] offset,
  input  logic [GAIN_W-1:0] gain,
  input  logic [AW-1:0]     preEffLo,
  input  qintStrobe_t       stb,
  output logic [DATA_W-1:0] energy
);
  localparam int CORR_W = DATA_W + 2;
  localparam int PROD_W = ACC_W + GAIN_W;

  logic [DATA_W-1:0] delayMem [PRE_DEPTH];
  logic [AW-1:0]     wrPtr;
  logic [AW-1:0]     rdPtr;
  logic [DATA_W-1:0] rdSample;
  logic signed [CORR_W-1:0] corr;
  logic signed [ACC_W-1:0]  accQ;
  logic [PROD_W-1:0] prodU;
  logic [ACC_W-1:0]  scaled;
  logic [DATA_W-1:0] energyNext;

  always_ff @(posedge clk) delayMem[wrPtr] <= sampleIn;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
    end else begin
      wrPtr <= wrPtr + 1'b1;
      if (stb.start)      rdPtr <= wrPtr - preEffLo;
      else if (stb.accEn) rdPtr <= rdPtr + 1'b1;
    end
  end

  assign rdSample = delayMem[rdPtr];
  assign corr = $signed({2'b00, rdSample}) - $signed({2'b00, baseline})
              + $signed({{2{offset[DATA_W-1]}}, offset});

  always_ff @(posedge clk) begin
    if (!rstN)          accQ <= '0;
    else if (stb.start) accQ <= '0;
    else if (stb.accEn) accQ <= accQ + ACC_W'(corr);
  end

  assign prodU  = PROD_W'($unsigned(accQ)) * PROD_W'(gain);
  assign scaled = ACC_W'(prodU >> GAIN_W);

  always_comb begin
    if (accQ[ACC_W-1])                energyNext = '0;
    else if (|scaled[ACC_W-1:DATA_W]) energyNext = '1;
    else                              energyNext = scaled[DATA_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (!rstN)          energy <= '0;
    else if (stb.latch) energy <= energyNext;
  end

  // R2: during the gate the read side trails the write side by P+1
  p_rd_lag_r2: assert property (@(posedge clk) disable iff (!rstN)
    stb.accEn |-> (AW'(wrPtr - rdPtr) == AW'(preEffLo + 1'b1)));

  // R4: a negative sum yields zero energy
  p_neg_zero_r4: assert property (@(posedge clk) disable iff (!rstN)
    (stb.latch && accQ[ACC_W-1]) |=> (energy == '0));
endmodule

// File: rtl/pretrig_charge_integrator.sv
module pretrig_charge_integrator
  import qint_pkg::*;
#(
  parameter int DATA_W    = 16,
  parameter int ACC_W     = 32,
  parameter int CNT_W     = 16,
  parameter int PRE_DEPTH = 64
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [DATA_W-1:0] sampleIn,
  input  logic              trigIn,
  input  logic [CNT_W-1:0]  intLen,
  input  logic [CNT_W-1:0]  preLen,
  input  logic [CNT_W-1:0]  pileLen,
  input  logic [DATA_W-1:0] gain,
  input  logic [DATA_W-1:0] offset,
  input  logic [DATA_W-1:0] baseline,
  output logic [DATA_W-1:0] energy,
  output logic              energyVld,
  output logic              pileup,
  output logic              intGate,
  output logic              busy
);
  localparam int AW = $clog2(PRE_DEPTH);
  localparam logic [CNT_W-1:0] PRE_MAX = CNT_W'(PRE_DEPTH - 1);

  qintStrobe_t      stb;
  logic [CNT_W-1:0] preEff;

  // R8: pre-trigger length limited by buffer depth
  assign preEff = (preLen > PRE_MAX) ? PRE_MAX : preLen;

  qint_ctrl #(.CNT_W(CNT_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .trigIn(trigIn),
    .preEff(preEff), .intLen(intLen), .pileLen(pileLen),
    .stb(stb), .energyVld(energyVld), .pileup(pileup),
    .intGate(intGate), .busy(busy)
  );

  qint_datapath #(
    .DATA_W(DATA_W), .ACC_W(ACC_W), .GAIN_W(DATA_W), .PRE_DEPTH(PRE_DEPTH)
  ) u_dp (
    .clk(clk), .rstN(rstN), .sampleIn(sampleIn), .baseline(baseline),
    .offset(offset), .gain(gain), .preEffLo(preEff[AW-1:0]),
    .stb(stb), .energy(energy)
  );

  // R6: a rejected event leaves energy untouched
  p_energy_hold_r6: assert property (@(posedge clk) disable iff (!rstN)
    pileup |-> $stable(energy));
endmodule

// File: tb/sim_pretrig_charge_integrator.sv
`timescale 1ns/1ps
module sim_pretrig_charge_integrator;
  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic        rstN = 1'b0;
  logic [15:0] sampleIn, intLen, preLen, pileLen, gain, offset, baseline;
  logic        trigIn = 1'b0;
  logic [15:0] energy;
  logic        energyVld, pileup, intGate, busy;

  pretrig_charge_integrator u0 (
    .clk(clk), .rstN(rstN), .sampleIn(sampleIn), .trigIn(trigIn),
    .intLen(intLen), .preLen(preLen), .pileLen(pileLen), .gain(gain),
    .offset(offset), .baseline(baseline), .energy(energy),
    .energyVld(energyVld), .pileup(pileup), .intGate(intGate), .busy(busy)
  );

  typedef struct {
    bit          isPile;
    logic [15:0] en;
    int          edgeF;
    string       tag;
  } item_t;

  item_t expQ[$];
  int checks = 0;
  int failures = 0;
  int edgeCnt = 0;
  logic [15:0] lastEnergy = 16'd0;
  bit done = 1'b0;

  function automatic int sampFn(int e);
    return 1800 + ((e * 73) % 251) + (((e % 17) == 0) ? 600 : 0);
  endfunction

  always @(posedge clk) edgeCnt++;

  initial sampleIn = 16'(sampFn(0));
  always @(negedge clk) sampleIn <= 16'(sampFn(edgeCnt));

  task automatic check(bit ok, string req, string what, longint act, longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // monitor: pops the scoreboard whenever a result strobe appears
  always @(negedge clk) begin
    if (rstN && (energyVld || pileup)) begin
      if (expQ.size() == 0) begin
        check(1'b0, "R7", "unexpected result strobe", 1, 0);
      end else begin
        item_t it;
        it = expQ.pop_front();
        check(!(energyVld && pileup), "R6", "both strobes high", 1, 0);
        check(pileup == it.isPile, it.isPile ? "R6" : "R5", "pileup flag",
              longint'(pileup), longint'(it.isPile));
        check(energy == it.en, it.tag, "energy", longint'(energy), longint'(it.en));
        check(edgeCnt - 1 == it.edgeF, "R5", "result edge",
              longint'(edgeCnt - 1), longint'(it.edgeF));
      end
    end
  end

  // driver: fires one event, optionally with a second trigger at edge T+k
  task automatic fire(string tag, int pre, int il, int pl, int g, int off,
                      int bl, int k);
    int t, p, n, f, gateSeen, busySeen;
    longint s, q;
    bit isPile;
    item_t it;
    @(negedge clk);
    preLen = 16'(pre); intLen = 16'(il); pileLen = 16'(pl);
    gain = 16'(g); offset = 16'(off); baseline = 16'(bl);
    trigIn = 1'b1;
    t = edgeCnt;
    p = (pre > 63) ? 63 : pre;
    n = (p + il > 0) ? p + il : 1;
    s = 0;
    for (int e = t - p; e < t - p + n; e++) s += longint'(sampFn(e) - bl + off);
    if (s < 0) q = 0;
    else begin
      q = (s * longint'(g)) >>> 16;
      if (q > 65535) q = 65535;
    end
    f = t + ((n > pl) ? n : pl) + 1;
    isPile = (k >= 1) && (k <= pl);
    it.isPile = isPile;
    it.en = isPile ? lastEnergy : 16'(q);
    it.edgeF = f;
    it.tag = tag;
    if (!isPile) lastEnergy = 16'(q);
    expQ.push_back(it);
    gateSeen = 0; busySeen = 0;
    for (int c = 1; c < 100000; c++) begin
      @(negedge clk);
      trigIn = (k > 0) && (edgeCnt == t + k);
      if (intGate) gateSeen++;
      if (!busy) break;
      busySeen++;
    end
    trigIn = 1'b0;
    check(gateSeen == n, "R2", "gate cycles", longint'(gateSeen), longint'(n));
    check(busySeen == f - t, "R7", "busy cycles", longint'(busySeen), longint'(f - t));
  endtask

  initial begin
    intLen = 0; preLen = 0; pileLen = 0; gain = 0; offset = 0; baseline = 0;
    repeat (3) @(negedge clk);
    check(energy == 0 && !energyVld && !pileup && !intGate && !busy, "R1",
          "reset outputs", longint'({energyVld, pileup, intGate, busy}), 0);
    rstN = 1'b1;
    @(negedge clk);
    check(energy == 0 && !energyVld && !pileup && !intGate && !busy, "R1",
          "idle after reset", longint'(energy), 0);
    repeat (100) @(negedge clk);
    fire("R3", 4, 10, 5, 16'h8000, 0, 1900, 0);
    fire("R2", 0, 1, 0, 16'hFFFF, 0, 1800, 0);
    fire("R2", 0, 0, 0, 16'hFFFF, 0, 1500, 0);
    fire("R3", 6, 8, 3, 16'h4000, -50, 1700, 0);
    fire("R4", 10, 50, 4, 16'hFFFF, 0, 0, 0);
    fire("R4", 3, 5, 2, 16'hFFFF, 0, 5000, 0);
    fire("R3", 2, 12, 4, 16'hC000, 25, 1850, 0);
    fire("R6", 4, 10, 8, 16'h8000, 0, 1900, 3);
    fire("R6", 4, 10, 5, 16'h8000, 0, 1900, 5);
    fire("R7", 4, 10, 2, 16'h8000, 0, 1900, 6);
    fire("R7", 2, 3, 30, 16'h8000, 0, 1900, 31);
    fire("R8", 200, 4, 2, 16'h2000, 0, 1800, 0);
    fire("R8", 63, 2, 2, 16'h2000, 0, 1800, 0);
    repeat (5) @(negedge clk);
    check(expQ.size() == 0, "R5", "results outstanding", longint'(expQ.size()), 0);
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      done = 1'b1;
      checks++;
      failures++;
      $display("FAIL R7 watchdog expired actual=1 expected=0");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule